// File: doc/BRIEF.md
# Dual-Strobe Serial/Parallel Shift Register

This block is a small register with two update modes: right-shift from a serial bit, and a parallel load of all bits at once. A mode input chooses which of two external strobe lines is in charge. When mode is LOW, the shift strobe is active. When mode is HIGH, the load strobe is active. The register updates only on a HIGH-to-LOW transition of the active strobe. Rising transitions, and any edge on the inactive strobe, do nothing.

Every input runs in one fast system clock domain. The strobes, the mode, the serial bit and the parallel bits all pass through the same multi-stage synchronizer, so the data and the strobe that captures it stay aligned. A falling transition counts only when the mode was the same on the previous system cycle. As a result, no mode change can ever update the register, whatever state the strobes are in.

Top module: `dual_strobe_shreg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `q_o` is cleared to all zeros.
- R2: With mode HIGH, a HIGH-to-LOW transition of `stb_load_i` copies `par_i` into `q_o`, with `q_o[k]` taking `par_i[k]`.
- R3: With mode LOW, a HIGH-to-LOW transition of `stb_shift_i` moves `ser_i` into `q_o[0]` and moves each `q_o[k]` into `q_o[k+1]`. The old top bit is dropped.
- R4: Rising transitions of either strobe, and any transition of the strobe that mode does not select, leave `q_o` unchanged.
- R5: While mode and both strobes hold steady, `q_o` holds its value, even if `ser_i` or `par_i` change.
- R6: Switching mode from LOW to HIGH while `stb_load_i` is HIGH leaves `q_o` unchanged.
- R7: Switching mode from HIGH to LOW while `stb_shift_i` is HIGH and `stb_load_i` is LOW leaves `q_o` unchanged.
- R8: If mode changes in the same synchronized cycle as a falling transition of the newly selected strobe, no update happens.
- R9: An update takes the data and mode values present with the falling strobe. It appears on `q_o` exactly STAGES+1 clock cycles after the inputs are applied (3 with the defaults).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_i | input | 1 | Serial data bit shifted into bit 0 |
| par_i | input | W | Parallel load data |
| mode_i | input | 1 | 0 selects shift strobe, 1 selects load strobe |
| stb_shift_i | input | 1 | Shift strobe, acts on its falling transition |
| stb_load_i | input | 1 | Load strobe, acts on its falling transition |
| q_o | output | W | Register contents |

## Verification
An input vector is applied one time unit after a rising edge. Its effect reaches `q_o` on the third rising edge after that: two synchronizer stages, then the register itself. The driver applies exactly one vector per cycle. For each vector it queues the expected register value, tagged with the cycle in which that value is due. The monitor samples on falling clock edges and compares an item only when the cycle counter equals the item's due cycle. Because every cycle is checked, an update that arrives one cycle early or late shows up as a mismatch.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
// Package: shared mode encoding for the dual-strobe shift register.
// Assumes mode 0 selects shifting and mode 1 selects parallel load.
package sreg_pkg;
    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_LOAD  = 1'b1
    } mode_e;
endpackage

// File: rtl/sreg_sync.sv
`timescale 1ns/1ps
// Module: sreg_sync
// A multi-stage flop chain that brings a vector of asynchronous inputs into
// the clk domain. Every bit gets the same delay, so the bits stay aligned.
// Assumes the inputs change rarely compared with clk. Clears to 0 on reset.
module sreg_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw inputs into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d_i;
            end
        end else begin : g_rest
            // Pass the value one stage further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sreg_fall_qual.sv
`timescale 1ns/1ps
// Module: sreg_fall_qual
// Chooses the strobe that the mode selects and raises fire_o for one cycle
// when that strobe falls. The mode must also match the previous cycle.
// Assumes all inputs are already synchronous to clk.
module sreg_fall_qual
    import sreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode_i,
    input  logic  stb_shift_i,
    input  logic  stb_load_i,
    output logic  fire_o
);
    logic  eff_now;
    logic  eff_q;
    mode_e mode_q;

    // Select the strobe enabled by the current mode.
    always_comb eff_now = (mode_i == MODE_LOAD) ? stb_load_i : stb_shift_i;

    // Remember last cycle's selected strobe and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_q  <= 1'b0;
            mode_q <= MODE_SHIFT;
        end else begin
            eff_q  <= eff_now;
            mode_q <= mode_i;
        end
    end

    // Qualified falling transition with a steady mode.
    always_comb fire_o = eff_q && !eff_now && (mode_i == mode_q);

    // A rise of the selected strobe never triggers an update.
    p_rise_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mode_i) && (mode_i == MODE_LOAD) && $rose(stb_load_i)) |-> !fire_o);
endmodule

// File: rtl/sreg_core.sv
`timescale 1ns/1ps
// Module: sreg_core
// The storage register. On fire_i it either shifts serial data in at bit 0
// or loads the parallel word, as mode_i says. Otherwise it holds.
// Assumes fire_i is a one-cycle qualified pulse. Clears to 0 on reset.
module sreg_core
    import sreg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire_i,
    input  mode_e        mode_i,
    input  logic         ser_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] nxt;

    // Next value: a parallel word, or the shifted word with ser_i at bit 0.
    always_comb nxt = (mode_i == MODE_LOAD) ? par_i : {q_o[W-2:0], ser_i};

    // Update only on a qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (fire_i) q_o <= nxt;
    end

    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (q_o == '0));
    p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && mode_i == MODE_LOAD) |=> (q_o == $past(par_i)));
    p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && mode_i == MODE_SHIFT) |=> (q_o == {$past(q_o[W-2:0]), $past(ser_i)}));
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> $stable(q_o));
endmodule

// File: rtl/dual_strobe_shreg.sv
`timescale 1ns/1ps
// Module: dual_strobe_shreg (top)
// A serial/parallel shift register driven by two falling-edge strobes, with
// mode choosing the active one. All inputs are asynchronous to clk and pass
// through one shared synchronizer. Assumes the strobes are much slower than clk.
module dual_strobe_shreg
    import sreg_pkg::*;
#(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_i,
    input  logic [W-1:0] par_i,
    input  logic         mode_i,
    input  logic         stb_shift_i,
    input  logic         stb_load_i,
    output logic [W-1:0] q_o
);
    localparam int SW = W + 4;

    logic [SW-1:0] raw_vec;
    logic [SW-1:0] syn_vec;
    logic [W-1:0]  par_s;
    logic          ser_s, shf_s, lod_s, mode_bit;
    mode_e         mode_s;
    logic          fire;

    // Bundle every input so they all see the same delay.
    always_comb raw_vec = {mode_i, stb_shift_i, stb_load_i, ser_i, par_i};

    sreg_sync #(.WIDTH(SW), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_vec), .q_o(syn_vec)
    );

    // Split the synchronized bundle back into its fields.
    always_comb begin
        {mode_bit, shf_s, lod_s, ser_s, par_s} = syn_vec;
        mode_s = mode_e'(mode_bit);
    end

    sreg_fall_qual u_qual (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_s),
        .stb_shift_i(shf_s), .stb_load_i(lod_s), .fire_o(fire)
    );

    sreg_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .mode_i(mode_s),
        .ser_i(ser_s), .par_i(par_s), .q_o(q_o)
    );

    // A mode change never updates the register.
    p_modechg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_s) |=> $stable(q_o));
    // Switching LOW to HIGH with the load strobe high leaves q_o alone.
    p_up_loadhigh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mode_bit) && lod_s) |=> $stable(q_o));
endmodule

// File: tb/sim_dual_strobe_shreg.sv
`timescale 1ns/1ps
module sim_dual_strobe_shreg;
    localparam int W   = 4;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser = 1'b0, mode = 1'b0, sa = 1'b0, sb = 1'b0;
    logic [W-1:0] par = '0;
    logic [W-1:0] q;

    dual_strobe_shreg #(.W(W), .STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_i(ser), .par_i(par), .mode_i(mode),
        .stb_shift_i(sa), .stb_load_i(sb), .q_o(q)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [W-1:0] exp;
        int           due;
        string        tag;
    } item_t;
    item_t sbq[$];

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [W-1:0] mstate = '0;
    logic pm = 0, pa = 0, pb = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each queued item in the cycle it is due.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (it.due != cyc || q !== it.exp) begin
                errors++;
                $display("FAIL %s: q=%b expected %b (due %0d now %0d)",
                         it.tag, q, it.exp, it.due, cyc);
            end
        end
    end

    // Driver: apply one vector per cycle and queue the expected state.
    task automatic apply(input logic m, input logic a, input logic b,
                         input logic s, input logic [W-1:0] p, input string force_tag);
        logic  eprev, enow;
        string tag;
        item_t it;
        @(posedge clk); #1;
        mode = m; sa = a; sb = b; ser = s; par = p;
        eprev = pm ? pb : pa;
        enow  = m ? b : a;
        if (m == pm && eprev && !enow) begin
            if (m) begin mstate = p; tag = "R2"; end
            else begin mstate = {mstate[W-2:0], s}; tag = "R3"; end
        end else if (m != pm) tag = "R8";
        else if (a != pa || b != pb) tag = "R4";
        else tag = "R5";
        if (force_tag != "") tag = force_tag;
        it.exp = mstate; it.due = cyc + LAT; it.tag = tag;
        sbq.push_back(it);
        pm = m; pa = a; pb = b;
    endtask

    task automatic do_reset();
        repeat (LAT + 2) @(posedge clk);
        #1;
        rst_n = 0; mode = 0; sa = 0; sb = 0; ser = 0; par = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if (q !== '0) begin
            errors++;
            $display("FAIL R1: q=%b expected %b", q, {W{1'b0}});
        end
        @(posedge clk); #1;
        rst_n = 1;
        mstate = '0; pm = 0; pa = 0; pb = 0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: q=%b expected completion", q);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();                                       // R1
        // R3: shift a pattern in with the shift strobe
        apply(0, 1, 0, 1, 4'h0, "R3");
        apply(0, 0, 0, 1, 4'h0, "R3");
        apply(0, 1, 0, 0, 4'h0, "R4");                    // rise only
        apply(0, 0, 0, 0, 4'h0, "R3");
        // R5: steady strobes, changing data
        apply(0, 0, 0, 1, 4'hF, "R5");
        apply(0, 0, 0, 0, 4'h3, "R5");
        // R4: falls of the load strobe in shift mode are ignored
        apply(0, 0, 1, 1, 4'hA, "R4");
        apply(0, 0, 0, 1, 4'hA, "R4");
        // R2: parallel load
        apply(1, 0, 0, 0, 4'h0, "R8");
        apply(1, 0, 1, 0, 4'h9, "R4");
        apply(1, 0, 0, 0, 4'h6, "R2");
        apply(1, 0, 0, 0, 4'h6, "R9");
        // R6: mode LOW->HIGH while load strobe high
        apply(0, 0, 1, 0, 4'hC, "R4");
        apply(1, 0, 1, 0, 4'hC, "R6");
        apply(1, 0, 1, 0, 4'hC, "R6");
        apply(1, 0, 0, 0, 4'h5, "R2");
        // R7: mode HIGH->LOW while shift strobe high, load strobe low
        apply(1, 1, 0, 1, 4'hE, "R4");
        apply(0, 1, 0, 1, 4'hE, "R7");
        apply(0, 1, 0, 1, 4'hE, "R7");
        apply(0, 0, 0, 1, 4'hE, "R3");
        // R8: mode change in the same cycle as a fall
        apply(0, 1, 1, 0, 4'h1, "R4");
        apply(1, 0, 0, 0, 4'h1, "R8");
        apply(1, 0, 1, 0, 4'h2, "R4");
        apply(0, 0, 0, 1, 4'h2, "R8");
        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic m;
            m = (($urandom % 6) == 0) ? ~pm : pm;
            apply(m, 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), "");
        end
        do_reset();                                       // R1 with data present
        apply(1, 0, 1, 0, 4'hB, "R4");
        apply(1, 0, 0, 0, 4'h7, "R2");
        repeat (LAT + 3) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule